// File: doc/BRIEF.md
# Serial Port Interrupt Controller with Modem Loopback

This block is the interrupt logic of a serial port. It keeps an eleven-bit
sticky status word that collects event pulses from the receive and transmit
data path. It ANDs that word with a software-written enable mask and fans the
result out to six interrupt lines: one combined line and five group lines for
receive, transmit, receive timeout, modem status and line errors. Software
clears individual status bits by writing ones to a clear port. Status bits are
never cleared by a zero.

The block also holds the port's control word. When the loopback bit of that
word is set, every control write copies the four software modem outputs into
the modem status flags. The same values are written into the four modem-status
interrupt bits in the same cycle. This makes a loopback self-test of the modem
handshake possible without any external wiring.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the status word and the mask are 0, the control word is 0x300, the modem flags are 0 and all six lines are low.
- R2: An event pulse on `evt_set` bit n sets status bit n, and the bit stays set after the pulse ends. Bit meanings: 10 overrun, 9 break, 8 parity, 7 framing, 6 receive timeout, 5 transmit, 4 receive, 3 DSR, 2 DCD, 1 CTS, 0 RI.
- R3: A pulse on `tx_wr` sets status bit 5.
- R4: `masked_rdata` always equals the status word ANDed with the mask, and `mask_rdata` shows the last mask written.
- R5: `irq_lines[0]` is high one clock after any masked bit is set.
- R6: `irq_lines[1]` to `irq_lines[5]` follow, one clock later, the masked groups {bit 4}, {bit 5}, {bit 6}, {bits 3..0} and {bits 10..7}.
- R7: A clear write clears exactly the status bits where `clr_wdata` holds a one. All other bits keep their value.
- R8: A status bit that has an event (or `tx_wr` for bit 5) in the same cycle as a clear write of that bit ends up set.
- R9: A control write with bit 7 set loads the modem flags with `flag_rdata[8]` = data bit 13, `flag_rdata[2]` = bit 12, `flag_rdata[0]` = bit 11 and `flag_rdata[1]` = bit 10.
- R10: The same write sets status bits 3, 2, 1 and 0 equal to the new DSR, DCD, CTS and RI flags, including clearing them when the flags are 0.
- R11: A control write with bit 7 clear stores the control word and leaves the flags and the status word unchanged.
- R12: A mask write changes the lines one clock after the write takes effect, and a zero mask drives every line low even when the status word is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 11 | Mask write data |
| clr_we | input | 1 | Clear write strobe |
| clr_wdata | input | 11 | Bits to clear (one means clear) |
| tx_wr | input | 1 | Transmit character written |
| evt_set | input | 11 | Event pulses from the data path |
| ctrl_rdata | output | 16 | Control word readback |
| mask_rdata | output | 11 | Mask readback |
| raw_rdata | output | 11 | Sticky status readback |
| masked_rdata | output | 11 | Status AND mask readback |
| flag_rdata | output | 9 | Modem flags (bits 8, 2, 1, 0) |
| irq_lines | output | 6 | Combined, receive, transmit, timeout, modem, error lines |

## Verification
The bench drives single events from each group with a full mask. A line that
follows the wrong bit, or a group with a missing member, then shows up as a
mismatch on exactly one line. A full status word seen through partial masks
separates the effect of the mask from the effect of the grouping. Clear writes
with mixed ones and zeros, and clears that coincide with events, tell a correct
bitwise clear with event priority apart from a whole-word clear or a clear that
wins. Control writes with loopback off, with loopback only and with a single
modem output check the flag mapping for each bit and show that modem bits are
cleared as well as set.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int RAW_W  = 11;
    localparam int LINE_N = 6;
    localparam int CTRL_W = 16;
    localparam int FLAG_W = 9;

    // status bit positions (decoded by software)
    localparam int B_RI  = 0;
    localparam int B_CTS = 1;
    localparam int B_DCD = 2;
    localparam int B_DSR = 3;
    localparam int B_RX  = 4;
    localparam int B_TX  = 5;
    localparam int B_RT  = 6;
    localparam int B_FE  = 7;
    localparam int B_PE  = 8;
    localparam int B_BE  = 9;
    localparam int B_OE  = 10;

    // control word fields
    localparam int C_LOOP = 7;
    localparam int C_DTR  = 10;
    localparam int C_RTS  = 11;
    localparam int C_OUT1 = 12;
    localparam int C_OUT2 = 13;
    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;

    // flag positions
    localparam int F_CTS = 0;
    localparam int F_DSR = 1;
    localparam int F_DCD = 2;
    localparam int F_RI  = 8;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [RAW_W-1:0]  mask;
        logic [RAW_W-1:0]  raw;
        logic [FLAG_W-1:0] flags;
        logic [LINE_N-1:0] lines;
    } uirq_state_t;

    function automatic logic [RAW_W-1:0] group_mask(input int line);
        logic [RAW_W-1:0] m;
        m = '0;
        case (line)
            0: m = '1;
            1: m[B_RX] = 1'b1;
            2: m[B_TX] = 1'b1;
            3: m[B_RT] = 1'b1;
            4: begin
                m[B_RI] = 1'b1; m[B_CTS] = 1'b1;
                m[B_DCD] = 1'b1; m[B_DSR] = 1'b1;
            end
            default: begin
                m[B_FE] = 1'b1; m[B_PE] = 1'b1;
                m[B_BE] = 1'b1; m[B_OE] = 1'b1;
            end
        endcase
        return m;
    endfunction
endpackage

// File: rtl/uirq_modem_loop.sv
module uirq_modem_loop
    import uirq_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_val,
    output logic [FLAG_W-1:0] flag_val,
    output logic [3:0]        modem_raw
);
    always_comb begin
        flag_val        = '0;
        flag_val[F_RI]  = ctrl_val[C_OUT2];
        flag_val[F_DCD] = ctrl_val[C_OUT1];
        flag_val[F_CTS] = ctrl_val[C_RTS];
        flag_val[F_DSR] = ctrl_val[C_DTR];

        modem_raw        = '0;
        modem_raw[B_DSR] = flag_val[F_DSR];
        modem_raw[B_DCD] = flag_val[F_DCD];
        modem_raw[B_CTS] = flag_val[F_CTS];
        modem_raw[B_RI]  = flag_val[F_RI];
    end
endmodule

// File: rtl/uirq_raw_next.sv
module uirq_raw_next
    import uirq_pkg::*;
(
    input  logic [RAW_W-1:0] raw_q,
    input  logic             clr_we,
    input  logic [RAW_W-1:0] clr_wdata,
    input  logic             loop_load,
    input  logic [3:0]       modem_raw,
    input  logic [RAW_W-1:0] evt_set,
    input  logic             tx_wr,
    output logic [RAW_W-1:0] raw_d
);
    logic [RAW_W-1:0] set_vec;

    always_comb begin
        set_vec       = evt_set;
        set_vec[B_TX] = evt_set[B_TX] | tx_wr;

        raw_d = raw_q;
        if (clr_we) begin
            raw_d = raw_d & ~clr_wdata;
        end
        if (loop_load) begin
            raw_d[3:0] = modem_raw;
        end
        // events last: nothing arriving this cycle is lost
        raw_d = raw_d | set_vec;
    end
endmodule

// File: rtl/uirq_line_fan.sv
module uirq_line_fan
    import uirq_pkg::*;
(
    input  logic [RAW_W-1:0]  masked,
    output logic [LINE_N-1:0] lines
);
    for (genvar g = 0; g < LINE_N; g++) begin : g_line
        assign lines[g] = |(masked & group_mask(g));
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [15:0]       ctrl_wdata,
    input  logic              mask_we,
    input  logic [10:0]       mask_wdata,
    input  logic              clr_we,
    input  logic [10:0]       clr_wdata,
    input  logic              tx_wr,
    input  logic [10:0]       evt_set,
    output logic [15:0]       ctrl_rdata,
    output logic [10:0]       mask_rdata,
    output logic [10:0]       raw_rdata,
    output logic [10:0]       masked_rdata,
    output logic [8:0]        flag_rdata,
    output logic [5:0]        irq_lines
);
    uirq_state_t st_d, st_q;

    logic [FLAG_W-1:0] loop_flags;
    logic [3:0]        loop_raw;
    logic              loop_load;
    logic [RAW_W-1:0]  raw_nxt;
    logic [RAW_W-1:0]  masked_q;
    logic [LINE_N-1:0] lines_nxt;

    assign loop_load = ctrl_we & ctrl_wdata[C_LOOP];
    assign masked_q  = st_q.raw & st_q.mask;

    uirq_modem_loop u_loop (
        .ctrl_val  (ctrl_wdata),
        .flag_val  (loop_flags),
        .modem_raw (loop_raw)
    );

    uirq_raw_next u_raw (
        .raw_q     (st_q.raw),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .loop_load (loop_load),
        .modem_raw (loop_raw),
        .evt_set   (evt_set),
        .tx_wr     (tx_wr),
        .raw_d     (raw_nxt)
    );

    uirq_line_fan u_fan (
        .masked (masked_q),
        .lines  (lines_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.raw   = raw_nxt;
        st_d.lines = lines_nxt;
        if (ctrl_we) begin
            st_d.ctrl = ctrl_wdata;
        end
        if (loop_load) begin
            st_d.flags = loop_flags;
        end
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl  <= CTRL_RST;
            st_q.mask  <= '0;
            st_q.raw   <= '0;
            st_q.flags <= '0;
            st_q.lines <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_rdata   = st_q.ctrl;
    assign mask_rdata   = st_q.mask;
    assign raw_rdata    = st_q.raw;
    assign masked_rdata = masked_q;
    assign flag_rdata   = st_q.flags;
    assign irq_lines    = st_q.lines;
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_we,
    input logic [15:0] ctrl_wdata,
    input logic        clr_we,
    input logic [10:0] clr_wdata,
    input logic        tx_wr,
    input logic [10:0] evt_set,
    input logic [10:0] raw_rdata,
    input logic [10:0] masked_rdata,
    input logic [8:0]  flag_rdata,
    input logic [5:0]  irq_lines
);
    // R5: combined line follows masked status one clock later
    assert_comb_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lines[0] == (|$past(masked_rdata)));

    // R6: combined line agrees with the union of the group lines
    assert_group_union_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lines[0] == (|irq_lines[5:1]));

    // R8: events always land in the status word
    assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((raw_rdata & $past(evt_set)) == $past(evt_set)));

    // R3: transmit write sets the transmit bit
    assert_tx_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> raw_rdata[5]);

    // R7: cleared bits without a coinciding event read zero
    assert_clear_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !(ctrl_we && ctrl_wdata[7]))
        |=> ((raw_rdata & $past(clr_wdata & ~evt_set & ~({5'd0, tx_wr, 5'd0}))) == 11'd0));

    // R9: loopback flag mapping
    assert_loop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[7]) |=>
        (flag_rdata[8] == $past(ctrl_wdata[13]) && flag_rdata[2] == $past(ctrl_wdata[12]) &&
         flag_rdata[0] == $past(ctrl_wdata[11]) && flag_rdata[1] == $past(ctrl_wdata[10])));

    // R11: non-loopback control write keeps the flags
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !ctrl_wdata[7]) |=> $stable(flag_rdata));
endmodule

bind uart_irq_ctrl uirq_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .clr_we       (clr_we),
    .clr_wdata    (clr_wdata),
    .tx_wr        (tx_wr),
    .evt_set      (evt_set),
    .raw_rdata    (raw_rdata),
    .masked_rdata (masked_rdata),
    .flag_rdata   (flag_rdata),
    .irq_lines    (irq_lines)
);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        mask_we = 1'b0;
    logic [10:0] mask_wdata = '0;
    logic        clr_we = 1'b0;
    logic [10:0] clr_wdata = '0;
    logic        tx_wr = 1'b0;
    logic [10:0] evt_set = '0;
    logic [15:0] ctrl_rdata;
    logic [10:0] mask_rdata;
    logic [10:0] raw_rdata;
    logic [10:0] masked_rdata;
    logic [8:0]  flag_rdata;
    logic [5:0]  irq_lines;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .tx_wr(tx_wr), .evt_set(evt_set),
        .ctrl_rdata(ctrl_rdata), .mask_rdata(mask_rdata),
        .raw_rdata(raw_rdata), .masked_rdata(masked_rdata),
        .flag_rdata(flag_rdata), .irq_lines(irq_lines)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // expected lines from the group definitions of R5/R6
    function automatic logic [5:0] exp_lines(input logic [10:0] m);
        logic [5:0] l;
        l[0] = |m;
        l[1] = m[4];
        l[2] = m[5];
        l[3] = m[6];
        l[4] = |m[3:0];
        l[5] = |m[10:7];
        return l;
    endfunction

    // one-cycle drive: set at negedge, one posedge, release at next negedge
    task automatic cyc(input logic cw, input logic [15:0] cd,
                       input logic mw, input logic [10:0] md,
                       input logic kw, input logic [10:0] kd,
                       input logic tw, input logic [10:0] ev);
        ctrl_we = cw; ctrl_wdata = cd; mask_we = mw; mask_wdata = md;
        clr_we = kw; clr_wdata = kd; tx_wr = tw; evt_set = ev;
        @(negedge clk);
        ctrl_we = 0; mask_we = 0; clr_we = 0; tx_wr = 0; evt_set = '0;
    endtask

    task automatic set_mask(input logic [10:0] m);
        cyc(0, 0, 1, m, 0, 0, 0, 0);
    endtask
    task automatic clear(input logic [10:0] c);
        cyc(0, 0, 0, 0, 1, c, 0, 0);
    endtask
    task automatic event_pulse(input logic [10:0] e);
        cyc(0, 0, 0, 0, 0, 0, 0, e);
    endtask

    task automatic t_reset();
        check("R1 raw", 16'(raw_rdata), 16'h0);
        check("R1 mask", 16'(mask_rdata), 16'h0);
        check("R1 ctrl", ctrl_rdata, 16'h0300);
        check("R1 flags", 16'(flag_rdata), 16'h0);
        check("R1 lines", 16'(irq_lines), 16'h0);
    endtask

    task automatic t_groups();
        logic [10:0] pats [5] = '{11'h010, 11'h040, 11'h200, 11'h004, 11'h001};
        set_mask(11'h7FF);
        foreach (pats[i]) begin
            event_pulse(pats[i]);
            check("R2 raw set", 16'(raw_rdata), 16'(pats[i]));
            @(negedge clk);
            check("R2 raw sticky", 16'(raw_rdata), 16'(pats[i]));
            check("R6 group lines", 16'(irq_lines), 16'(exp_lines(pats[i])));
            check("R5 combined", 16'(irq_lines[0]), 16'h1);
            clear(11'h7FF);
            @(negedge clk);
            check("R7 full clear", 16'(raw_rdata), 16'h0);
            check("R5 lines low", 16'(irq_lines), 16'h0);
        end
    endtask

    task automatic t_tx();
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        check("R3 tx bit", 16'(raw_rdata), 16'h020);
        @(negedge clk);
        check("R3 tx line", 16'(irq_lines), 16'(exp_lines(11'h020)));
        clear(11'h7FF);
    endtask

    task automatic t_mask();
        logic [10:0] ms [4] = '{11'h000, 11'h780, 11'h00F, 11'h050};
        event_pulse(11'h7FF);
        foreach (ms[i]) begin
            set_mask(ms[i]);
            check("R4 mask rd", 16'(mask_rdata), 16'(ms[i]));
            check("R4 masked", 16'(masked_rdata), 16'(ms[i]));
            check("R12 lines lag", 16'(irq_lines), 16'(exp_lines(i == 0 ? 11'h7FF : ms[i-1])));
            @(negedge clk);
            check("R12 lines", 16'(irq_lines), 16'(exp_lines(ms[i])));
        end
        set_mask(11'h7FF);
        clear(11'h7FF);
    endtask

    task automatic t_partial_clear();
        event_pulse(11'h5A5);
        clear(11'h181);
        check("R7 partial clear", 16'(raw_rdata), 16'h424);
        cyc(0, 0, 0, 0, 1, 11'h420, 1, 11'h400);
        check("R8 event beats clear", 16'(raw_rdata), 16'h424);
        clear(11'h7FF);
    endtask

    task automatic t_loop();
        event_pulse(11'h080);
        cyc(1, 16'h3F00, 0, 0, 0, 0, 0, 0);
        check("R11 ctrl stored", ctrl_rdata, 16'h3F00);
        check("R11 flags kept", 16'(flag_rdata), 16'h0);
        check("R11 raw kept", 16'(raw_rdata), 16'h080);
        cyc(1, 16'h3F80, 0, 0, 0, 0, 0, 0);
        check("R9 all flags", 16'(flag_rdata), 16'h107);
        check("R10 modem raw set", 16'(raw_rdata), 16'h08F);
        @(negedge clk);
        check("R10 modem line", 16'(irq_lines[4]), 16'h1);
        clear(11'h00F);
        cyc(1, 16'h0880, 0, 0, 0, 0, 0, 0);
        check("R9 rts only", 16'(flag_rdata), 16'h001);
        check("R10 cts only", 16'(raw_rdata), 16'h082);
        cyc(1, 16'h2080, 0, 0, 0, 0, 0, 0);
        check("R9 out2 only", 16'(flag_rdata), 16'h100);
        check("R10 ri only", 16'(raw_rdata), 16'h081);
        cyc(1, 16'h0480, 0, 0, 0, 0, 0, 0);
        check("R9 dtr only", 16'(flag_rdata), 16'h002);
        check("R10 dsr only", 16'(raw_rdata), 16'h088);
        cyc(1, 16'h1080, 0, 0, 0, 0, 0, 0);
        check("R9 out1 only", 16'(flag_rdata), 16'h004);
        check("R10 dcd only", 16'(raw_rdata), 16'h084);
        cyc(1, 16'h0080, 0, 0, 0, 0, 0, 0);
        check("R10 modem cleared", 16'(raw_rdata), 16'h080);
        check("R9 flags cleared", 16'(flag_rdata), 16'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_groups();
        t_tx();
        t_mask();
        t_partial_clear();
        t_loop();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule